// File: doc/BRIEF.md
# Buffered UART Baud Divisor Generator

This block produces the oversampling tick that paces a UART transmitter and receiver. Software programs a 13-bit divisor through two byte-wide registers on a simple write port. The low register holds divisor bits 7:0. The high register holds divisor bits 12:8 in its bits 4:0. A write to the high register only parks its divisor bits in a holding register. When the low register is written later, the parked bits and the new low byte load into the working divisor on the same clock edge. The divisor therefore never passes through a half-updated value.

The tick counter stays idle after reset until the receive or transmit enable is seen for the first time. A sticky flag records that event. The counter is also idle whenever the working divisor is zero. Once running, it emits a one-clock tick every divisor clocks.

The high register also carries an enable bit for the receive-input active-edge interrupt. This bit decides whether an external edge flag drives the interrupt request output.

Top module: `baud_divisor_gen`

## Requirements
- R1: Register select encoding for both write and read is 0 for the high register and 1 for the low register. A high-register read returns {0, edge interrupt enable, 0, working divisor[12:8]}, bit 7 first. A low-register read returns working divisor[7:0].
- R2: After reset, the high register reads 0x00, the low register reads 0x04, the edge interrupt enable is 0 and `tick` is 0.
- R3: A high-register write changes neither the working divisor nor the divisor bits returned by a high-register read.
- R4: A low-register write loads {parked high bits, written byte} into the working divisor in one step. High-register writes that are never followed by a low-register write leave the tick period unchanged.
- R5: After reset, no tick appears until `rx_enable` or `tx_enable` has been 1 on at least one clock edge.
- R6: Once either enable has been seen, ticks keep coming after both enables return to 0. Only reset stops them.
- R7: No tick is produced while the working divisor is 0.
- R8: With a nonzero working divisor N, `tick` is a one-clock pulse that repeats every N clocks. When N is 1, `tick` stays high.
- R9: A low-register write restarts the count. The first tick after it appears N clocks after the loading edge, whatever the count was before.
- R10: Bit 6 of a high-register write sets the edge interrupt enable at once. `edge_irq` equals `edge_flag` while the enable is 1 and stays 0 while it is 0.
- R11: Bits 7 and 5 of the high register always read 0. Values written to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write register select (0 high, 1 low) |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read register select (0 high, 1 low) |
| rd_data | output | 8 | Read data of the selected register |
| rx_enable | input | 1 | Receiver enable |
| tx_enable | input | 1 | Transmitter enable |
| edge_flag | input | 1 | Receive-input active-edge flag |
| edge_irq | output | 1 | Edge interrupt request |
| tick | output | 1 | Oversampling tick, one clock wide |

## Verification
The bench builds the block with its default 13-bit divisor and a low-byte reset value of 0x04. The reset divisor of 4 lets the bench check the first-enable gate and the sticky behaviour within a few clocks. The full-width divisor lets a parked high byte produce a period of 258, which shows that both halves load together. Divisors of 0, 1 and 10 cover the idle case, the constant-high tick and a restart in the middle of a count.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int BYTE_W = 8;
    localparam int HI_FIELD_W = 5;

    typedef enum logic {
        SEL_HI = 1'b0,
        SEL_LO = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic                  rsv7;
        logic                  edge_ie;
        logic                  rsv5;
        logic [HI_FIELD_W-1:0] div_hi;
    } hi_reg_t;

    function automatic logic [BYTE_W-1:0] pack_hi(input logic ie,
                                                  input logic [HI_FIELD_W-1:0] hi);
        hi_reg_t r;
        r.rsv7    = 1'b0;
        r.edge_ie = ie;
        r.rsv5    = 1'b0;
        r.div_hi  = hi;
        return r;
    endfunction

endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs
    import baud_pkg::*;
#(
    parameter int DIV_W = 13,
    parameter logic [7:0] LOW_RESET = 8'h04
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             rd_sel,
    output logic [7:0]       rd_data,
    output logic [DIV_W-1:0] work_div,
    output logic             edge_ie,
    output logic             load
);
    localparam int HI_BITS = DIV_W - BYTE_W;

    hi_reg_t               wr_hi;
    logic [HI_BITS-1:0]    parked_hi;
    logic [HI_FIELD_W-1:0] hi_view;

    assign wr_hi = hi_reg_t'(wr_data);
    assign load  = wr_en && (reg_sel_e'(wr_sel) == SEL_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            parked_hi <= '0;
            work_div  <= {{HI_BITS{1'b0}}, LOW_RESET};
            edge_ie   <= 1'b0;
        end else if (wr_en) begin
            if (reg_sel_e'(wr_sel) == SEL_HI) begin
                parked_hi <= wr_hi.div_hi[HI_BITS-1:0];
                edge_ie   <= wr_hi.edge_ie;
            end else begin
                work_div  <= {parked_hi, wr_data};
            end
        end
    end

    assign hi_view = HI_FIELD_W'(work_div >> BYTE_W);

    always_comb begin
        if (reg_sel_e'(rd_sel) == SEL_HI)
            rd_data = pack_hi(edge_ie, hi_view);
        else
            rd_data = work_div[BYTE_W-1:0];
    end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_req,
    input  logic [DIV_W-1:0] divisor,
    input  logic             load,
    output logic             tick
);
    logic             armed;
    logic [DIV_W-1:0] count;
    logic             running;

    assign running = armed && (divisor != '0);

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else if (en_req) armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !running || load) begin
            count <= DIV_W'(1);
            tick  <= 1'b0;
        end else if (count == divisor) begin
            count <= DIV_W'(1);
            tick  <= 1'b1;
        end else begin
            count <= count + DIV_W'(1);
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/baud_divisor_gen.sv
module baud_divisor_gen #(
    parameter int DIV_W = 13,
    parameter logic [7:0] LOW_RESET = 8'h04
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       rd_sel,
    output logic [7:0] rd_data,
    input  logic       rx_enable,
    input  logic       tx_enable,
    input  logic       edge_flag,
    output logic       edge_irq,
    output logic       tick
);
    logic [DIV_W-1:0] work_div;
    logic             edge_ie;
    logic             load;

    baud_div_regs #(.DIV_W(DIV_W), .LOW_RESET(LOW_RESET)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .work_div(work_div), .edge_ie(edge_ie), .load(load)
    );

    baud_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .en_req(rx_enable || tx_enable),
        .divisor(work_div), .load(load), .tick(tick)
    );

    assign edge_irq = edge_flag && edge_ie;
endmodule

module baud_divisor_gen_chk #(
    parameter int DIV_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             wr_sel,
    input logic             rx_enable,
    input logic             tx_enable,
    input logic             tick,
    input logic [DIV_W-1:0] work_div
);
    logic seen_en;
    always_ff @(posedge clk) begin
        if (rst) seen_en <= 1'b0;
        else if (rx_enable || tx_enable) seen_en <= 1'b1;
    end

    // R5
    no_tick_before_enable_chk: assert property (@(posedge clk) disable iff (rst)
        !seen_en |-> !tick);

    // R3
    hi_write_holds_div_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=> $stable(work_div));

    // R7
    zero_div_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (work_div == '0) |=> !tick);

    // R9
    load_restarts_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel) |=> !tick);

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && work_div > DIV_W'(1) && !(wr_en && wr_sel)) |=> !tick);
endmodule

bind baud_divisor_gen baud_divisor_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .rx_enable(rx_enable), .tx_enable(tx_enable), .tick(tick),
    .work_div(work_div)
);

// File: tb/baud_divisor_gen_tb.sv
module baud_divisor_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       rx_enable = 1'b0;
    logic       tx_enable = 1'b0;
    logic       edge_flag = 1'b0;
    logic       edge_irq;
    logic       tick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_divisor_gen u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .rx_enable(rx_enable), .tx_enable(tx_enable),
        .edge_flag(edge_flag), .edge_irq(edge_irq), .tick(tick)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic sel, output logic [7:0] d);
        rd_sel = sel;
        #1;
        d = rd_data;
    endtask

    task automatic cycles_to_tick(input int limit, output int n);
        n = 0;
        while (!tick && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic period(input int limit, output int n);
        int dummy;
        cycles_to_tick(limit, dummy);
        @(negedge clk);
        n = 1;
        while (!tick && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        int n;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        read_reg(1'b0, d); check("R2 hi reset", d, 8'h00);
        read_reg(1'b1, d); check("R2 lo reset", d, 8'h04);
        check("R2 tick reset", tick, 0);
        cycles_to_tick(40, n);
        check("R5 no tick before enable", n, 40);
    endtask

    task automatic t_first_enable;
        int n;
        @(negedge clk); rx_enable = 1'b1;
        @(negedge clk); rx_enable = 1'b0;
        period(100, n);
        check("R8 reset divisor period", n, 4);
        period(100, n);
        check("R6 sticky after enables drop", n, 4);
    endtask

    task automatic t_staging;
        logic [7:0] d;
        int n;
        write_reg(1'b0, 8'h01);
        read_reg(1'b0, d); check("R3 hi read unchanged", d, 8'h00);
        period(100, n); check("R4 hi-only write no effect", n, 4);
        write_reg(1'b1, 8'h02);
        cycles_to_tick(1000, n); check("R9 latency after load 258", n, 258);
        read_reg(1'b0, d); check("R1 hi read after load", d, 8'h01);
        read_reg(1'b1, d); check("R1 lo read after load", d, 8'h02);
        period(1000, n); check("R4 atomic period 258", n, 258);
    endtask

    task automatic t_zero;
        int n;
        write_reg(1'b0, 8'h00);
        write_reg(1'b1, 8'h00);
        cycles_to_tick(300, n); check("R7 zero divisor silent", n, 300);
        write_reg(1'b1, 8'h03);
        cycles_to_tick(100, n); check("R9 latency 3 after zero", n, 3);
        period(100, n); check("R8 period 3", n, 3);
    endtask

    task automatic t_div1;
        int n;
        write_reg(1'b1, 8'h01);
        period(100, n); check("R8 divisor 1 period", n, 1);
        @(negedge clk); check("R8 divisor 1 stays high", tick, 1);
    endtask

    task automatic t_restart;
        int n;
        write_reg(1'b1, 8'd10);
        cycles_to_tick(100, n);
        repeat (4) @(negedge clk);
        write_reg(1'b1, 8'd10);
        cycles_to_tick(100, n); check("R9 restart mid count", n, 10);
        period(100, n); check("R8 period 10", n, 10);
    endtask

    task automatic t_irq;
        logic [7:0] d;
        edge_flag = 1'b1;
        #1; check("R10 irq gated when disabled", edge_irq, 0);
        write_reg(1'b0, 8'h40);
        check("R10 irq passes when enabled", edge_irq, 1);
        read_reg(1'b0, d); check("R1 ie bit reads back", d, 8'h40);
        edge_flag = 1'b0;
        #1; check("R10 irq follows flag", edge_irq, 0);
    endtask

    task automatic t_reserved;
        logic [7:0] d;
        int n;
        write_reg(1'b0, 8'hA0);
        read_reg(1'b0, d); check("R11 reserved bits read zero", d, 8'h00);
        write_reg(1'b1, 8'd10);
        period(100, n); check("R11 reserved bits no divisor effect", n, 10);
        write_reg(1'b0, 8'hFF);
        write_reg(1'b1, 8'h00);
        read_reg(1'b0, d); check("R11 full write reads 0x5F", d, 8'h5F);
    endtask

    initial begin
        t_reset();
        t_first_enable();
        t_staging();
        t_zero();
        t_div1();
        t_restart();
        t_irq();
        t_reserved();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule